// File: doc/BRIEF.md
# Narrow-to-wide memory bridge

This block lets a 32-bit register-style processor bus reach a synchronous memory whose native access is a 144-bit word, moved as two consecutive 72-bit beats. Each beat holds two 36-bit lanes, and every lane carries one 32-bit processor word plus four padding bits. Software sees an ordinary word-addressed space, but the memory can only be written a whole 16-byte aligned group at a time.

Reads fetch the full memory word, take the lane that holds the addressed word and return its low 32 bits. Writes are collected in a staging buffer, one word per bus access. The memory write is issued only when the last word of the group arrives. A write to a different group while words are still staged discards them and raises a sticky error flag. A read of a word that is still staged is answered from the buffer.

Top module: `nwb_bridge`

## Requirements
- R1: While `rst_n` is low, `mem_wr` and `mem_rd` stay low. Reset clears the staging buffer and `err_flag`. After reset, `bus_rdy` is 1 and `bus_ack` is 0.
- R2: A read that misses the staging buffer drives `mem_rd` for exactly one cycle, with `mem_addr` = byte address >> 4. `mem_wr` is never high in the same cycle. Counting from the cycle in which the request is accepted, `bus_ack` comes 2+RD_LAT cycles later for words 0 and 1 and 3+RD_LAT cycles later for words 2 and 3.
- R3: Byte address bits [3:2] give the word index. Word 0 is read from beat 0 bits [67:36], word 1 from beat 0 bits [31:0], word 2 from beat 1 bits [67:36] and word 3 from beat 1 bits [31:0]. Padding bits [71:68] and [35:32] of the returned beat are ignored.
- R4: A write to word index 0, 1 or 2 issues no memory command. It is acknowledged one cycle after acceptance, and `bus_ack` lasts one cycle.
- R5: A write to word index 3 commits the group. `mem_wr` is high for two consecutive cycles with a fixed `mem_addr`. The first beat is {4'h0, word0, 4'h0, word1} and the second is {4'h0, word2, 4'h0, word3}. `bus_ack` follows 3 cycles after acceptance.
- R6: Words of the group that were not written since the last commit, drop or reset are committed as zero. After a commit the buffer is empty.
- R7: A write to a different group while words are staged discards those words and sets `err_flag`. The flag stays set until reset. The new word starts a fresh group, and no memory command is issued.
- R8: A read whose group matches the staged group and whose word is staged returns the staged value 1 cycle after acceptance, without a memory command. Unstaged words of that group are read from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request, accepted when `bus_rdy` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write word |
| bus_rdy | output | 1 | Bridge idle, request can be accepted |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DATA_W | Read word, valid with `bus_ack` |
| err_flag | output | 1 | Sticky flag for a discarded partial group |
| mem_wr | output | 1 | Write beat strobe |
| mem_rd | output | 1 | Read command strobe |
| mem_addr | output | ADDR_W-4 | Memory word address |
| mem_wdata | output | 2*LANE_W | Write beat |
| mem_rdata | input | 2*LANE_W | Read beat, beat 0 RD_LAT cycles after `mem_rd`, beat 1 one cycle later |

## Verification
The memory model is preloaded with padding nibbles of all ones. A bridge that leaks padding into read data returns a wrong word, and one that swaps lanes or beats returns a neighbour's word. Commits from a partly written group expose a buffer that is not cleared, because stale words from an earlier group show up in memory. A change of group in mid-fill checks three things: the error flag, that no memory write is issued, and that the dropped word is not served later. Acknowledge latency is measured for every access, so an off-by-one in the read-beat timing or an early commit is reported. A read of a staged word followed by a reset shows whether staging survives either path.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR,
      ST_RDCMD,
      ST_RDWAIT,
      ST_ACK
   } nwb_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nwb_stage.sv
module nwb_stage #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int IDX_W  = 2,
   parameter int GRP_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [GRP_W-1:0]        wr_grp,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    clr,
   output logic [WORDS-1:0]        vld,
   output logic [GRP_W-1:0]        grp,
   output logic [WORDS*DATA_W-1:0] flat,
   output logic                    err
);

   logic [DATA_W-1:0] wbuf [WORDS];
   logic              other_grp;

   assign other_grp = (|vld) && (grp != wr_grp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         grp <= '0;
         err <= 1'b0;
         for (int k = 0; k < WORDS; k++) wbuf[k] <= '0;
      end else if (clr) begin
         vld <= '0;
         for (int k = 0; k < WORDS; k++) wbuf[k] <= '0;
      end else if (wr_en) begin
         grp <= wr_grp;
         if (other_grp) begin
            err <= 1'b1;
            vld <= '0;
            vld[wr_idx] <= 1'b1;
            for (int k = 0; k < WORDS; k++)
               wbuf[k] <= (IDX_W'(k) == wr_idx) ? wr_data : '0;
         end else begin
            vld[wr_idx]  <= 1'b1;
            wbuf[wr_idx] <= wr_data;
         end
      end
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_flat
      assign flat[g*DATA_W +: DATA_W] = wbuf[g];
   end

endmodule

// File: rtl/nwb_beat_pack.sv
module nwb_beat_pack #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 36,
   parameter int LPB    = 2,
   parameter int BEATS  = 2
) (
   input  logic [LPB*BEATS*DATA_W-1:0] words,
   input  logic [$clog2(BEATS)-1:0]    beat_sel,
   output logic [LPB*LANE_W-1:0]       beat
);

   localparam int PAD_W  = LANE_W - DATA_W;
   localparam int LSEL_W = $clog2(LPB);
   localparam int IDX_W  = $clog2(LPB * BEATS);

   for (genvar l = 0; l < LPB; l++) begin : g_lane
      logic [IDX_W-1:0] widx;
      assign widx = {beat_sel, LSEL_W'(l)};
      assign beat[(LPB-1-l)*LANE_W +: LANE_W] =
         {{PAD_W{1'b0}}, words[widx*DATA_W +: DATA_W]};
   end

endmodule

// File: rtl/nwb_lane_pick.sv
module nwb_lane_pick #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 36,
   parameter int LPB    = 2
) (
   input  logic [LPB*LANE_W-1:0]  beat,
   input  logic [$clog2(LPB)-1:0] lane_sel,
   output logic [DATA_W-1:0]      word
);

   always_comb begin
      word = '0;
      for (int l = 0; l < LPB; l++)
         if ($clog2(LPB)'(l) == lane_sel)
            word = beat[(LPB-1-l)*LANE_W +: DATA_W];
   end

endmodule

// File: rtl/nwb_rd_track.sv
module nwb_rd_track #(
   parameter int RD_LAT = 2,
   parameter int BEATS  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [$clog2(BEATS)-1:0] beat_sel,
   output logic                     hit
);

   localparam int CNT_W = $clog2(RD_LAT + BEATS + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] tgt;
   logic             run;

   assign hit = run && (cnt == tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tgt <= '0;
         run <= 1'b0;
      end else if (start) begin
         run <= 1'b1;
         cnt <= CNT_W'(1);
         tgt <= CNT_W'(RD_LAT) + CNT_W'(beat_sel);
      end else if (run) begin
         if (hit) run <= 1'b0;
         else     cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/nwb_bridge.sv
module nwb_bridge #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LANE_W = 36,
   parameter int LPB    = 2,
   parameter int BEATS  = 2,
   parameter int RD_LAT = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic                    bus_rdy,
   output logic                    bus_ack,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    err_flag,
   output logic                    mem_wr,
   output logic                    mem_rd,
   output logic [ADDR_W-5:0]       mem_addr,
   output logic [LPB*LANE_W-1:0]   mem_wdata,
   input  logic [LPB*LANE_W-1:0]   mem_rdata
);
   import nwb_pkg::*;

   localparam int WORDS   = LPB * BEATS;
   localparam int IDX_W   = $clog2(WORDS);
   localparam int LSEL_W  = $clog2(LPB);
   localparam int BSEL_W  = $clog2(BEATS);
   localparam int GRP_LSB = 2 + IDX_W;
   localparam int MA_W    = ADDR_W - GRP_LSB;

   if (LANE_W <= DATA_W) begin : g_bad_lane
      $error("LANE_W must exceed DATA_W");
   end
   if (!is_pow2(LPB) || LPB < 2 || !is_pow2(BEATS) || BEATS < 2) begin : g_bad_shape
      $error("LPB and BEATS must be powers of two, at least 2");
   end
   if (GRP_LSB != 4) begin : g_bad_group
      $error("group must span 16 bytes");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end

   nwb_state_e               state;
   logic [BSEL_W-1:0]        wbeat;
   logic [MA_W-1:0]          rgrp;
   logic [IDX_W-1:0]         ridx;
   logic [DATA_W-1:0]        rdata_q;

   logic                     acc;
   logic [IDX_W-1:0]         in_idx;
   logic [MA_W-1:0]          in_grp;
   logic                     stg_wr;
   logic                     stg_clr;
   logic [WORDS-1:0]         stg_vld;
   logic [MA_W-1:0]          stg_grp;
   logic [WORDS*DATA_W-1:0]  stg_flat;
   logic                     stage_hit;
   logic                     last_beat;
   logic [LPB*LANE_W-1:0]    packed_beat;
   logic [DATA_W-1:0]        picked;
   logic                     rd_hit;
   logic                     unused_low;

   assign unused_low = &{1'b0, bus_addr[1:0]};

   assign acc       = bus_req && (state == ST_IDLE);
   assign in_idx    = bus_addr[2 +: IDX_W];
   assign in_grp    = bus_addr[GRP_LSB +: MA_W];
   assign stg_wr    = acc && bus_we;
   assign last_beat = (wbeat == BSEL_W'(BEATS - 1));
   assign stg_clr   = (state == ST_WR) && last_beat;
   assign stage_hit = (stg_grp == in_grp) && stg_vld[in_idx];

   nwb_stage #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS),
      .IDX_W  (IDX_W),
      .GRP_W  (MA_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stg_wr),
      .wr_idx  (in_idx),
      .wr_grp  (in_grp),
      .wr_data (bus_wdata),
      .clr     (stg_clr),
      .vld     (stg_vld),
      .grp     (stg_grp),
      .flat    (stg_flat),
      .err     (err_flag)
   );

   nwb_beat_pack #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .LPB    (LPB),
      .BEATS  (BEATS)
   ) u_pack (
      .words    (stg_flat),
      .beat_sel (wbeat),
      .beat     (packed_beat)
   );

   nwb_lane_pick #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .LPB    (LPB)
   ) u_pick (
      .beat     (mem_rdata),
      .lane_sel (ridx[LSEL_W-1:0]),
      .word     (picked)
   );

   nwb_rd_track #(
      .RD_LAT (RD_LAT),
      .BEATS  (BEATS)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (state == ST_RDCMD),
      .beat_sel (ridx[IDX_W-1 -: BSEL_W]),
      .hit      (rd_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         wbeat   <= '0;
         rgrp    <= '0;
         ridx    <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (acc) begin
               if (bus_we) begin
                  wbeat <= '0;
                  state <= (in_idx == IDX_W'(WORDS - 1)) ? ST_WR : ST_ACK;
               end else if (stage_hit) begin
                  rdata_q <= stg_flat[in_idx*DATA_W +: DATA_W];
                  state   <= ST_ACK;
               end else begin
                  rgrp  <= in_grp;
                  ridx  <= in_idx;
                  state <= ST_RDCMD;
               end
            end
            ST_WR: begin
               if (last_beat) state <= ST_ACK;
               else           wbeat <= wbeat + BSEL_W'(1);
            end
            ST_RDCMD:  state <= ST_RDWAIT;
            ST_RDWAIT: if (rd_hit) begin
               rdata_q <= picked;
               state   <= ST_ACK;
            end
            ST_ACK:    state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign bus_rdy   = (state == ST_IDLE);
   assign bus_ack   = (state == ST_ACK);
   assign bus_rdata = rdata_q;
   assign mem_wr    = (state == ST_WR);
   assign mem_rd    = (state == ST_RDCMD);
   assign mem_wdata = mem_wr ? packed_beat : '0;
   assign mem_addr  = mem_wr ? stg_grp : (mem_rd ? rgrp : '0);

endmodule

// File: rtl/nwb_bridge_chk.sv
module nwb_bridge_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LANE_W = 36,
   parameter int LPB    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_rdy,
   input logic                  bus_ack,
   input logic                  err_flag,
   input logic                  mem_wr,
   input logic                  mem_rd,
   input logic [ADDR_W-5:0]     mem_addr,
   input logic [LPB*LANE_W-1:0] mem_wdata
);

   localparam int PAD_W = LANE_W - DATA_W;

   logic pad_set;
   always_comb begin
      pad_set = 1'b0;
      for (int l = 0; l < LPB; l++)
         pad_set = pad_set | (|mem_wdata[l*LANE_W + DATA_W +: PAD_W]);
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !mem_wr && !mem_rd);

   // R2
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R2
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R5
   wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |=> mem_wr && $stable(mem_addr));

   // R5
   wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && $past(mem_wr) |=> !mem_wr);

   // R5
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> !pad_set);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R4
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack && bus_rdy);

endmodule

bind nwb_bridge nwb_bridge_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANE_W (LANE_W),
   .LPB    (LPB)
) u_chk (.*);

// File: tb/nwb_bridge_test.sv
module nwb_bridge_test;

   localparam int RD_LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rdy, bus_ack, err_flag, mem_wr, mem_rd;
   logic [31:0] bus_rdata;
   logic [7:0]  mem_addr;
   logic [71:0] mem_wdata;
   logic [71:0] mem_rdata;

   always #4 clk = ~clk;

   nwb_bridge #(.RD_LAT(RD_LAT)) uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .err_flag(err_flag),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // memory model
   logic [71:0] b0 [256];
   logic [71:0] b1 [256];
   logic        pv [RD_LAT+2];
   logic [7:0]  pa [RD_LAT+2];
   logic        wphase;
   int          wr_cmds, rd_cyc;

   function automatic logic [31:0] init_w(input int a, input int w);
      return {16'hC3D0, 8'(a), 8'(w)};
   endfunction

   function automatic logic [71:0] beat(input logic [31:0] u, input logic [31:0] l);
      return {4'h0, u, 4'h0, l};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < 256; a++) begin
            b0[a] <= {4'hF, init_w(a, 0), 4'hF, init_w(a, 1)};
            b1[a] <= {4'hF, init_w(a, 2), 4'hF, init_w(a, 3)};
         end
         for (int j = 0; j < RD_LAT + 2; j++) begin
            pv[j] <= 1'b0;
            pa[j] <= '0;
         end
         wphase  <= 1'b0;
         wr_cmds <= 0;
         rd_cyc  <= 0;
      end else begin
         pv[1] <= mem_rd;
         pa[1] <= mem_addr;
         for (int j = 2; j < RD_LAT + 2; j++) begin
            pv[j] <= pv[j-1];
            pa[j] <= pa[j-1];
         end
         if (mem_rd) rd_cyc <= rd_cyc + 1;
         if (mem_wr) begin
            if (!wphase) begin
               b0[mem_addr] <= mem_wdata;
               wr_cmds <= wr_cmds + 1;
            end else begin
               b1[mem_addr] <= mem_wdata;
            end
            wphase <= !wphase;
         end
      end
   end

   always_comb begin
      if (pv[RD_LAT])        mem_rdata = b0[pa[RD_LAT]];
      else if (pv[RD_LAT+1]) mem_rdata = b1[pa[RD_LAT+1]];
      else                   mem_rdata = '0;
   end

   // scoreboard
   typedef struct {
      bit          rd;
      logic [31:0] exp;
      int          t0;
      int          lat;
      string       tag;
   } item_t;

   item_t sb[$];

   task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                      input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && bus_ack) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R4 unexpected ack", 72'(bus_ack), 72'(0));
         end else begin
            item_t it;
            it = sb.pop_front();
            chk((cyc - it.t0) == it.lat, {it.tag, " latency"},
                72'(cyc - it.t0), 72'(it.lat));
            if (it.rd)
               chk(bus_rdata === it.exp, {it.tag, " data"}, 72'(bus_rdata), 72'(it.exp));
         end
      end
   end

   task automatic issue(input bit we, input logic [11:0] a, input logic [31:0] d,
                        input int lat, input string tag);
      item_t it;
      @(negedge clk);
      while (!bus_rdy) @(negedge clk);
      bus_req   = 1'b1;
      bus_we    = we;
      bus_addr  = a;
      bus_wdata = d;
      it.rd = !we; it.exp = d; it.t0 = cyc; it.lat = lat; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      bus_req = 1'b0;
      while (sb.size() != 0) @(negedge clk);
   endtask

   localparam int LMISS0 = 2 + RD_LAT;
   localparam int LMISS1 = 3 + RD_LAT;

   initial begin
      int w0, r0;
      #2 rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!mem_wr && !mem_rd && !bus_ack, "R1 quiet in reset",
             72'({mem_wr, mem_rd, bus_ack}), 72'(0));
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_rdy && !bus_ack && !err_flag, "R1 state after reset",
          72'({bus_rdy, bus_ack, err_flag}), 72'(4));

      // R2 R3: lane/beat selection with padding set in memory
      issue(1'b0, 12'h020, init_w(2, 0), LMISS0, "R3 read w0");
      issue(1'b0, 12'h024, init_w(2, 1), LMISS0, "R3 read w1");
      issue(1'b0, 12'h028, init_w(2, 2), LMISS1, "R3 read w2");
      issue(1'b0, 12'h02C, init_w(2, 3), LMISS1, "R2 read w3");
      chk(rd_cyc == 4, "R2 one mem_rd cycle per miss", 72'(rd_cyc), 72'(4));

      // R4 R5: full group
      w0 = wr_cmds;
      issue(1'b1, 12'h030, 32'h1111_1111, 1, "R4 stage w0");
      issue(1'b1, 12'h034, 32'h2222_2222, 1, "R4 stage w1");
      issue(1'b1, 12'h038, 32'h3333_3333, 1, "R4 stage w2");
      chk(wr_cmds == w0, "R4 no write before word 3", 72'(wr_cmds), 72'(w0));
      issue(1'b1, 12'h03C, 32'h4444_4444, 3, "R5 commit");
      chk(wr_cmds == w0 + 1, "R5 one commit", 72'(wr_cmds), 72'(w0 + 1));
      chk(b0[3] === beat(32'h1111_1111, 32'h2222_2222), "R5 beat0", b0[3],
          beat(32'h1111_1111, 32'h2222_2222));
      chk(b1[3] === beat(32'h3333_3333, 32'h4444_4444), "R5 beat1", b1[3],
          beat(32'h3333_3333, 32'h4444_4444));
      issue(1'b0, 12'h034, 32'h2222_2222, LMISS0, "R6 buffer empty after commit");

      // R8 R6: partial group
      r0 = rd_cyc;
      issue(1'b1, 12'h054, 32'h5555_0001, 1, "R4 stage g5 w1");
      issue(1'b0, 12'h054, 32'h5555_0001, 1, "R8 staged hit");
      chk(rd_cyc == r0, "R8 no mem_rd on hit", 72'(rd_cyc), 72'(r0));
      issue(1'b0, 12'h058, init_w(5, 2), LMISS1, "R8 unstaged word from memory");
      issue(1'b1, 12'h05C, 32'h5555_0003, 3, "R6 commit partial");
      chk(b0[5] === beat(32'h0, 32'h5555_0001), "R6 zero fill beat0", b0[5],
          beat(32'h0, 32'h5555_0001));
      chk(b1[5] === beat(32'h0, 32'h5555_0003), "R6 zero fill beat1", b1[5],
          beat(32'h0, 32'h5555_0003));

      // R7: group change mid-fill
      chk(!err_flag, "R7 err clear before", 72'(err_flag), 72'(0));
      w0 = wr_cmds;
      issue(1'b1, 12'h060, 32'h6666_0000, 1, "R7 stage g6");
      issue(1'b1, 12'h074, 32'h7777_0001, 1, "R7 switch group");
      chk(err_flag, "R7 err set", 72'(err_flag), 72'(1));
      chk(wr_cmds == w0, "R7 no write on drop", 72'(wr_cmds), 72'(w0));
      issue(1'b1, 12'h070, 32'h7777_0000, 1, "R7 fill g7 w0");
      issue(1'b1, 12'h078, 32'h7777_0002, 1, "R7 fill g7 w2");
      issue(1'b1, 12'h07C, 32'h7777_0003, 3, "R7 commit g7");
      chk(b0[7] === beat(32'h7777_0000, 32'h7777_0001), "R7 new group kept", b0[7],
          beat(32'h7777_0000, 32'h7777_0001));
      chk(b0[6] === {4'hF, init_w(6, 0), 4'hF, init_w(6, 1)}, "R7 g6 untouched",
          b0[6], {4'hF, init_w(6, 0), 4'hF, init_w(6, 1)});
      issue(1'b0, 12'h060, init_w(6, 0), LMISS0, "R7 dropped word not served");
      chk(err_flag, "R7 err sticky", 72'(err_flag), 72'(1));

      // R6: word 3 alone
      issue(1'b1, 12'h09C, 32'h9999_0003, 3, "R6 lone word 3 commit");
      chk(b0[9] === beat(32'h0, 32'h0), "R6 lone beat0", b0[9], beat(32'h0, 32'h0));
      chk(b1[9] === beat(32'h0, 32'h9999_0003), "R6 lone beat1", b1[9],
          beat(32'h0, 32'h9999_0003));

      // R1: reset clears staging and error
      issue(1'b1, 12'h080, 32'h8888_0000, 1, "R1 stage before reset");
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!err_flag && bus_rdy, "R1 err cleared by reset",
          72'({err_flag, bus_rdy}), 72'(1));
      issue(1'b0, 12'h080, init_w(8, 0), LMISS0, "R1 staging cleared by reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=hung exp=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule